// File: doc/BRIEF.md
# Prioritised Interrupt Processor Interface

This block is the processor-facing half of an interrupt controller. It keeps one pending bit for each source and each processor. A distributor beside it supplies, for every source, the enable, an 8-bit priority, the trigger type (edge or level), the pending-clear model (one processor or all processors), the set of target processors and the current input level. The distributor also sends one-cycle pulses that mark a source pending for a given processor. For each processor the block picks the best candidate among the sources that are both enabled and pending. It then gates that candidate through the processor's priority mask and its running priority, and drives the processor's interrupt line.

Software reaches each processor's view through one register port, with a processor-select input. A read of the acknowledge register takes the offered interrupt: it records what was running before, clears the pending state and makes the new interrupt the running one. A write to the end-of-interrupt register completes an interrupt. Interrupts that preempt each other form a chain of predecessors held per processor and per source. Completing the running interrupt hands control back to its predecessor. Completing an interrupt further down the chain unlinks it from the chain and leaves the running one in place.

Top module: `irq_cpuif`

## Requirements
- R1: After reset every processor has priority mask 0xF0, interface disabled, highest-pending and acknowledge reads of 1023, running-priority read of 0x100, and its interrupt line low.
- R2: Among sources that are enabled and pending for a processor, the lowest numeric priority is chosen. On a tie the lowest source number is chosen. Pending state is per processor.
- R3: The chosen source is reported as highest pending only when its priority is less than or equal to the mask; otherwise highest pending reads 1023 and the line is low.
- R4: The interrupt line is high only when a source is reported and its priority is strictly below the running priority.
- R5: With the global enable input low, or the processor's interface enable clear, that processor's line is low and highest pending reads 1023.
- R6: An acknowledge read returns 1023 and changes no state when nothing is reported or the reported priority is not below the running priority.
- R7: A successful acknowledge returns the source number, makes it running with its priority, and clears its pending bit for the acknowledging processor; each read strobe acts once.
- R8: For a source in the all-processors model, a successful acknowledge clears its pending bit for every processor. In the one-processor model the other processors keep theirs.
- R9: An end-of-interrupt write is ignored when the processor has nothing running.
- R10: Completing the running interrupt restores its predecessor as running together with that predecessor's priority; with no predecessor the running priority returns to 0x100.
- R11: Completing an interrupt that is not running leaves the running interrupt and priority unchanged and removes it from the predecessor chain, so later completions skip it.
- R12: On end-of-interrupt, a level-type source that is enabled, targets this processor and has its input high is made pending again; an edge-type source is not.
- R13: Register offsets: 0x00 control (bit 0 enable), 0x04 mask (low 8 bits kept), 0x0C acknowledge, 0x10 end-of-interrupt (ID in bits 9:0), 0x14 running priority, 0x18 highest pending; other read offsets return 0. Read data appears on the clock edge that takes the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dist_en | input | 1 | Global enable from the distributor |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | NUM_SRC*8 | Per-source priority, source i at bits [8i+7:8i] |
| src_edge | input | NUM_SRC | 1 = edge type, 0 = level type |
| src_all | input | NUM_SRC | 1 = acknowledge clears pending for all processors |
| src_target | input | NUM_SRC*NUM_CPU | Target bit for source i, processor c at bit i*NUM_CPU+c |
| src_line | input | NUM_SRC | Current input level of each source |
| pend_set | input | NUM_SRC*NUM_CPU | One-cycle pulse marking source i pending for processor c (bit i*NUM_CPU+c) |
| irq_o | output | NUM_CPU | Interrupt line per processor |
| reg_cpu | input | CPU_W | Processor selected by the register port |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (ignored while reg_wr is high) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with 16 sources and 2 processors. That size keeps every source number small enough to place ties, mask boundaries and three-deep preemption chains by hand. The second processor makes the per-processor pending bits observable, so the difference between the one-processor and all-processors clear on acknowledge can be seen through the other processor's highest-pending read. A level source with a controllable input shows re-pending at completion, and an edge source shows its absence.

// File: rtl/irq_cpuif_pkg.sv
package irq_cpuif_pkg;
  localparam int          ID_W      = 10;
  localparam int          PRIO_W    = 8;
  localparam logic [9:0]  NO_IRQ    = 10'd1023;
  localparam logic [8:0]  IDLE_PRIO = 9'h100;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_ACK   = 8'h0C;
  localparam logic [7:0] OFF_EOI   = 8'h10;
  localparam logic [7:0] OFF_RPRIO = 8'h14;
  localparam logic [7:0] OFF_HPEND = 8'h18;

  // Widen an 8-bit priority to the 9-bit running-priority domain.
  function automatic logic [8:0] widen(input logic [7:0] p);
    return {1'b0, p};
  endfunction

  // A candidate beats the current best only when strictly lower.
  function automatic logic beats(input logic [8:0] cand, input logic [8:0] best);
    return cand < best;
  endfunction
endpackage

// File: rtl/irq_cpuif_select.sv
module irq_cpuif_select
  import irq_cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]   cand,
  input  logic [NUM_SRC*8-1:0] prio_flat,
  output logic [9:0]           best_id,
  output logic [8:0]           best_prio
);
  // Ascending scan with a strict compare: ties keep the lower number.
  always_comb begin
    best_id   = NO_IRQ;
    best_prio = IDLE_PRIO;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && beats(widen(prio_flat[i*8 +: 8]), best_prio)) begin
        best_id   = 10'(i);
        best_prio = widen(prio_flat[i*8 +: 8]);
      end
    end
  end
endmodule

// File: rtl/irq_cpuif_chain.sv
module irq_cpuif_chain
  import irq_cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] run_id,
  input  logic       push,
  input  logic [9:0] push_id,
  input  logic [9:0] push_prev,
  input  logic       pop,
  input  logic       cut,
  input  logic [9:0] cut_id,
  output logic [9:0] pred_id
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [9:0] link_q [NUM_SRC];
  logic [9:0] cut_next;

  always_comb begin
    pred_id  = NO_IRQ;
    cut_next = NO_IRQ;
    if (int'(run_id) < NUM_SRC) pred_id  = link_q[run_id[IDX_W-1:0]];
    if (int'(cut_id) < NUM_SRC) cut_next = link_q[cut_id[IDX_W-1:0]];
  end

  // Links of nodes that leave the chain are reset to NO_IRQ, so only live
  // members can match the parallel search done for an out-of-order cut.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_SRC; j++) link_q[j] <= NO_IRQ;
    end else if (push) begin
      link_q[push_id[IDX_W-1:0]] <= push_prev;
    end else if (pop) begin
      link_q[run_id[IDX_W-1:0]] <= NO_IRQ;
    end else if (cut) begin
      for (int j = 0; j < NUM_SRC; j++)
        if (link_q[j] == cut_id) link_q[j] <= cut_next;
      link_q[cut_id[IDX_W-1:0]] <= NO_IRQ;
    end
  end
endmodule

// File: rtl/irq_cpuif.sv
module irq_cpuif
  import irq_cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dist_en,
  input  logic [NUM_SRC-1:0]         src_en,
  input  logic [NUM_SRC*8-1:0]       src_prio,
  input  logic [NUM_SRC-1:0]         src_edge,
  input  logic [NUM_SRC-1:0]         src_all,
  input  logic [NUM_SRC*NUM_CPU-1:0] src_target,
  input  logic [NUM_SRC-1:0]         src_line,
  input  logic [NUM_SRC*NUM_CPU-1:0] pend_set,
  output logic [NUM_CPU-1:0]         irq_o,
  input  logic [CPU_W-1:0]           reg_cpu,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [7:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  function automatic logic [8:0] prio_of(input logic [9:0] id);
    if (int'(id) < NUM_SRC) return widen(src_prio[int'(id)*8 +: 8]);
    return IDLE_PRIO;
  endfunction

  // Per-processor state
  logic [NUM_SRC-1:0] pend_q     [NUM_CPU];
  logic               cpu_en_q   [NUM_CPU];
  logic [7:0]         mask_q     [NUM_CPU];
  logic [9:0]         run_id_q   [NUM_CPU];
  logic [8:0]         run_prio_q [NUM_CPU];

  // Named internal events
  logic [9:0]         best_id    [NUM_CPU];
  logic [8:0]         best_prio  [NUM_CPU];
  logic [9:0]         hp_id      [NUM_CPU];
  logic [9:0]         pred_id    [NUM_CPU];
  logic [NUM_CPU-1:0] ack_take;
  logic [NUM_CPU-1:0] eoi_hit;
  logic [NUM_CPU-1:0] eoi_pop;
  logic [NUM_CPU-1:0] eoi_cut;
  logic [NUM_CPU-1:0] repend;

  logic [NUM_CPU*10-1:0] hp_flat;
  logic [NUM_CPU*10-1:0] run_id_flat;
  logic [NUM_CPU*9-1:0]  run_prio_flat;

  logic [9:0] eoi_id;
  logic       eoi_src_ok;
  logic       rd_go;
  assign eoi_id     = reg_wdata[9:0];
  assign eoi_src_ok = int'(eoi_id) < NUM_SRC;
  assign rd_go      = reg_rd && !reg_wr;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic sel;
    logic lvl_ok;
    assign sel = (int'(reg_cpu) == c);

    irq_cpuif_select #(.NUM_SRC(NUM_SRC)) u_sel (
      .cand      (src_en & pend_q[c]),
      .prio_flat (src_prio),
      .best_id   (best_id[c]),
      .best_prio (best_prio[c])
    );

    assign hp_id[c] = (dist_en && cpu_en_q[c] && best_prio[c] <= widen(mask_q[c]))
                      ? best_id[c] : NO_IRQ;
    assign irq_o[c] = (hp_id[c] != NO_IRQ) && (best_prio[c] < run_prio_q[c]);

    assign ack_take[c] = sel && rd_go && reg_addr == OFF_ACK && irq_o[c];
    assign eoi_hit[c]  = sel && reg_wr && reg_addr == OFF_EOI && run_id_q[c] != NO_IRQ;
    assign eoi_pop[c]  = eoi_hit[c] && eoi_id == run_id_q[c];
    assign eoi_cut[c]  = eoi_hit[c] && eoi_id != run_id_q[c] && eoi_src_ok;

    always_comb begin
      lvl_ok = 1'b0;
      if (eoi_src_ok) begin
        lvl_ok = !src_edge[eoi_id[IDX_W-1:0]] && src_en[eoi_id[IDX_W-1:0]]
                 && src_line[eoi_id[IDX_W-1:0]]
                 && src_target[int'(eoi_id)*NUM_CPU + c];
      end
    end
    assign repend[c] = eoi_hit[c] && lvl_ok;

    irq_cpuif_chain #(.NUM_SRC(NUM_SRC)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_id    (run_id_q[c]),
      .push      (ack_take[c]),
      .push_id   (hp_id[c]),
      .push_prev (run_id_q[c]),
      .pop       (eoi_pop[c]),
      .cut       (eoi_cut[c]),
      .cut_id    (eoi_id),
      .pred_id   (pred_id[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cpu_en_q[c]   <= 1'b0;
        mask_q[c]     <= 8'hF0;
        run_id_q[c]   <= NO_IRQ;
        run_prio_q[c] <= IDLE_PRIO;
      end else begin
        if (sel && reg_wr && reg_addr == OFF_CTRL) cpu_en_q[c] <= reg_wdata[0];
        if (sel && reg_wr && reg_addr == OFF_MASK) mask_q[c]   <= reg_wdata[7:0];
        if (ack_take[c]) begin
          run_id_q[c]   <= hp_id[c];
          run_prio_q[c] <= best_prio[c];
        end else if (eoi_pop[c]) begin
          run_id_q[c]   <= pred_id[c];
          run_prio_q[c] <= prio_of(pred_id[c]);
        end
      end
    end

    assign hp_flat[c*10 +: 10]      = hp_id[c];
    assign run_id_flat[c*10 +: 10]  = run_id_q[c];
    assign run_prio_flat[c*9 +: 9]  = run_prio_q[c];
  end

  // Pending bits: clears from any acknowledge, then sets win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) pend_q[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int i = 0; i < NUM_SRC; i++) begin
          logic clr;
          logic set;
          clr = 1'b0;
          for (int k = 0; k < NUM_CPU; k++)
            if (ack_take[k] && int'(hp_id[k]) == i && (k == c || src_all[i])) clr = 1'b1;
          set = pend_set[i*NUM_CPU + c] || (repend[c] && int'(eoi_id) == i);
          pend_q[c][i] <= (pend_q[c][i] && !clr) || set;
        end
      end
    end
  end

  // Registered read data for the selected processor.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (rd_go) begin
      reg_rdata <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        if (int'(reg_cpu) == c) begin
          case (reg_addr)
            OFF_CTRL:  reg_rdata <= {31'd0, cpu_en_q[c]};
            OFF_MASK:  reg_rdata <= {24'd0, mask_q[c]};
            OFF_ACK:   reg_rdata <= {22'd0, (irq_o[c] ? hp_id[c] : NO_IRQ)};
            OFF_RPRIO: reg_rdata <= {23'd0, run_prio_q[c]};
            OFF_HPEND: reg_rdata <= {22'd0, hp_id[c]};
            default:   reg_rdata <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_cpuif_checks.sv
module irq_cpuif_checks
  import irq_cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 2,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dist_en,
  input logic [NUM_CPU-1:0]    irq_o,
  input logic [CPU_W-1:0]      reg_cpu,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [7:0]            reg_addr,
  input logic [31:0]           reg_rdata,
  input logic [NUM_CPU*10-1:0] hp_flat,
  input logic [NUM_CPU*10-1:0] run_id_flat,
  input logic [NUM_CPU*9-1:0]  run_prio_flat,
  input logic [NUM_CPU-1:0]    ack_take
);
  AST_ACK_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == OFF_ACK) |=>
      (reg_rdata == 32'(NO_IRQ) || reg_rdata < 32'(NUM_SRC))); // R6

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en |-> !irq_o[c]); // R5

    AST_LINE_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> hp_flat[c*10 +: 10] != NO_IRQ); // R4

    AST_ACK_RAISES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take[c] |=> (run_prio_flat[c*9 +: 9] < $past(run_prio_flat[c*9 +: 9])
                       && run_id_flat[c*10 +: 10] == $past(hp_flat[c*10 +: 10]))); // R7

    AST_EOI_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_EOI && int'(reg_cpu) == c
       && run_id_flat[c*10 +: 10] == NO_IRQ) |=>
        ($stable(run_id_flat[c*10 +: 10]) && $stable(run_prio_flat[c*9 +: 9]))); // R9

    AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      run_id_flat[c*10 +: 10] == NO_IRQ |-> run_prio_flat[c*9 +: 9] == IDLE_PRIO); // R10
  end
endmodule

bind irq_cpuif irq_cpuif_checks #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .dist_en       (dist_en),
  .irq_o         (irq_o),
  .reg_cpu       (reg_cpu),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .hp_flat       (hp_flat),
  .run_id_flat   (run_id_flat),
  .run_prio_flat (run_prio_flat),
  .ack_take      (ack_take)
);

// File: tb/irq_cpuif_test.sv
module irq_cpuif_test;
  localparam int NS = 16;
  localparam int NC = 2;
  localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_UNUSED = 8'h08,
                         A_ACK = 8'h0C, A_EOI = 8'h10, A_RPRIO = 8'h14, A_HP = 8'h18;
  localparam int NONE = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_en = 1'b1;
  logic [NS-1:0] src_en = '1;
  logic [NS*8-1:0] src_prio = '1;
  logic [NS-1:0] src_edge = '1;
  logic [NS-1:0] src_all = '0;
  logic [NS*NC-1:0] src_target = '1;
  logic [NS-1:0] src_line = '0;
  logic [NS*NC-1:0] pend_set = '0;
  logic [NC-1:0] irq_o;
  logic [0:0] reg_cpu = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  irq_cpuif #(.NUM_SRC(NS), .NUM_CPU(NC)) uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic rd(input int cpu, input logic [7:0] a, output int v);
    @(negedge clk);
    reg_cpu = 1'(cpu); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input int cpu, input logic [7:0] a, input int d);
    @(negedge clk);
    reg_cpu = 1'(cpu); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input int src, input int cpu);
    @(negedge clk);
    pend_set[src*NC + cpu] = 1'b1;
    @(negedge clk);
    pend_set = '0;
  endtask

  task automatic expect_rd(input string tag, input int cpu, input logic [7:0] a, input int exp);
    int v;
    rd(cpu, a, v);
    check(tag, v, exp);
  endtask

  task automatic setp(input int src, input int p);
    src_prio[src*8 +: 8] = 8'(p);
  endtask

  task automatic t_reset;
    check("R1 irq low", int'(irq_o), 0);
    expect_rd("R1 mask", 0, A_MASK, 'hF0);
    expect_rd("R1 ctrl", 0, A_CTRL, 0);
    expect_rd("R1 hp", 0, A_HP, NONE);
    expect_rd("R1 rprio", 1, A_RPRIO, 'h100);
    expect_rd("R1 ack", 0, A_ACK, NONE);
    expect_rd("R13 unused offset", 0, A_UNUSED, 0);
    wr(0, A_CTRL, 1); wr(1, A_CTRL, 1);
    expect_rd("R13 ctrl bit0", 0, A_CTRL, 1);
  endtask

  task automatic t_select;
    setp(3, 'h40); setp(5, 'h20); setp(9, 'h20);
    pulse(3, 0); pulse(9, 0); pulse(5, 0);
    expect_rd("R2 lowest prio, tie to lower id", 0, A_HP, 5);
    check("R2 irq high", int'(irq_o[0]), 1);
    expect_rd("R2 other cpu not pending", 1, A_HP, NONE);
  endtask

  task automatic t_mask;
    wr(0, A_MASK, 'h1F);
    expect_rd("R3 above mask hidden", 0, A_HP, NONE);
    check("R3 irq low", int'(irq_o[0]), 0);
    wr(0, A_MASK, 'h20);
    expect_rd("R3 equal to mask shown", 0, A_HP, 5);
    wr(0, A_MASK, 'h1F0);
    expect_rd("R13 mask low 8 bits", 0, A_MASK, 'hF0);
  endtask

  task automatic t_enables;
    @(negedge clk); dist_en = 1'b0;
    @(negedge clk);
    check("R5 global off irq", int'(irq_o[0]), 0);
    expect_rd("R5 global off hp", 0, A_HP, NONE);
    dist_en = 1'b1;
    wr(0, A_CTRL, 0);
    check("R5 cpu off irq", int'(irq_o[0]), 0);
    expect_rd("R5 cpu off hp", 0, A_HP, NONE);
    wr(0, A_CTRL, 1);
    check("R5 re-enabled irq", int'(irq_o[0]), 1);
  endtask

  task automatic t_ack;
    expect_rd("R7 ack returns id", 0, A_ACK, 5);
    expect_rd("R7 running prio", 0, A_RPRIO, 'h20);
    expect_rd("R7 pending cleared, next shown", 0, A_HP, 9);
    check("R4 equal prio no irq", int'(irq_o[0]), 0);
    expect_rd("R6 ack blocked", 0, A_ACK, NONE);
    expect_rd("R6 no state change", 0, A_RPRIO, 'h20);
  endtask

  task automatic t_nest;
    setp(2, 'h10);
    pulse(2, 0);
    check("R4 higher prio preempts", int'(irq_o[0]), 1);
    expect_rd("R7 nested ack", 0, A_ACK, 2);
    wr(0, A_EOI, 'hFC02);
    expect_rd("R10 R13 predecessor prio", 0, A_RPRIO, 'h20);
    wr(0, A_EOI, 5);
    expect_rd("R10 idle prio", 0, A_RPRIO, 'h100);
    check("R4 pending 9 now fires", int'(irq_o[0]), 1);
  endtask

  task automatic t_out_of_order;
    expect_rd("R7 ack 9", 0, A_ACK, 9);
    pulse(2, 0);
    expect_rd("R7 ack 2", 0, A_ACK, 2);
    setp(1, 'h08);
    pulse(1, 0);
    expect_rd("R7 ack 1", 0, A_ACK, 1);
    wr(0, A_EOI, 2);
    expect_rd("R11 running unchanged", 0, A_RPRIO, 'h08);
    wr(0, A_EOI, 1);
    expect_rd("R11 unlinked node skipped", 0, A_RPRIO, 'h20);
    wr(0, A_EOI, 9);
    expect_rd("R10 chain empty", 0, A_RPRIO, 'h100);
    expect_rd("R2 remaining source", 0, A_HP, 3);
  endtask

  task automatic t_level;
    expect_rd("R7 ack 3", 0, A_ACK, 3);
    wr(0, A_EOI, 3);
    expect_rd("R12 edge not re-pended", 0, A_HP, NONE);
    src_edge[7] = 1'b0; setp(7, 'h50); src_line[7] = 1'b1;
    wr(0, A_EOI, 7);
    expect_rd("R9 idle eoi no re-pend", 0, A_HP, NONE);
    expect_rd("R9 idle eoi prio", 0, A_RPRIO, 'h100);
    pulse(7, 0);
    expect_rd("R7 ack level", 0, A_ACK, 7);
    wr(0, A_EOI, 7);
    expect_rd("R12 level re-pended", 0, A_HP, 7);
    expect_rd("R7 ack level again", 0, A_ACK, 7);
    src_line[7] = 1'b0;
    wr(0, A_EOI, 7);
    expect_rd("R12 line low not re-pended", 0, A_HP, NONE);
  endtask

  task automatic t_model;
    setp(11, 'h30); src_all[11] = 1'b1;
    pulse(11, 0); pulse(11, 1);
    expect_rd("R8 cpu1 sees shared", 1, A_HP, 11);
    expect_rd("R8 cpu0 ack shared", 0, A_ACK, 11);
    expect_rd("R8 all-model cleared on cpu1", 1, A_HP, NONE);
    wr(0, A_EOI, 11);
    setp(12, 'h30);
    pulse(12, 0); pulse(12, 1);
    expect_rd("R8 cpu0 ack private", 0, A_ACK, 12);
    expect_rd("R8 one-model kept on cpu1", 1, A_HP, 12);
    expect_rd("R7 cpu1 ack", 1, A_ACK, 12);
    wr(0, A_EOI, 12); wr(1, A_EOI, 12);
    expect_rd("R10 cpu1 idle", 1, A_RPRIO, 'h100);
    expect_rd("R8 cpu1 empty", 1, A_HP, NONE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_mask();
    t_enables();
    t_ack();
    t_nest();
    t_out_of_order();
    t_level();
    t_model();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule